// File: doc/BRIEF.md
# Multichannel Hit Acquisition Manager

This block runs the digital side of hit capture for a bank of self-triggered channels. Each channel owns a small store of analog sample slots, two by default, and each slot holds one charge and fine-time pair. When a channel's discriminator fires, the block registers the pulse and finds that channel's next free slot. It then sends a one-cycle hold strobe to that slot and records the current coarse time value against it. The coarse time comes from a free-running counter that advances on a 10 MHz time-base enable and is presented in Gray code.

The slots of each channel form a first-in, first-out queue. A downstream sequencer reads the oldest entry of any channel through a small read port and erases entries once they are converted. Capture never stalls for reads or erases. A hit that lands on a channel whose slots are all taken is dropped and marked in a sticky overflow flag. The block also gives a single OR of all registered triggers.

Top module: `hit_acq_mgr`

## Requirements
- R1: After reset every slot is empty, every overflow flag and hold strobe is low, the coarse time output is zero and no read result is valid.
- R2: Trigger inputs are sampled into a register on each clock edge. A hit is a rising edge of that registered value, so a trigger held high for several cycles makes exactly one hit.
- R3: A hit on a channel with a free slot marks slot (head + occupied count) mod DEPTH as full on the next edge. That slot's hold strobe is high for exactly that one cycle.
- R4: The timestamp stored with a slot equals the coarse Gray value shown in the cycle in which the hit was taken.
- R5: The coarse counter adds one in binary on each cycle with the time-base enable high. Its output is the Gray code of that count, value XOR (value >> 1).
- R6: After all-ones in binary, the coarse counter goes back to zero.
- R7: A hit on a channel whose slots are all full, with no erase of that channel in the same cycle, is dropped. The slot contents stay unchanged and the channel's overflow flag sets and stays set until reset.
- R8: The any-trigger output is the OR of the registered triggers of all channels.
- R9: A read request names a channel. One cycle later the read-valid output pulses, read-ok shows whether that channel was non-empty, and the read timestamp carries its oldest stamp. A read changes no occupancy.
- R10: An erase request on a non-empty channel clears its oldest slot at the next edge and moves the head to the following slot. An erase on an empty channel changes nothing.
- R11: When a hit and an erase reach a full channel in the same cycle, the hit goes into the slot the erase frees and no overflow is flagged.
- R12: Channels work independently. Hits on any number of channels in one cycle are all captured, whatever reads or erases are under way elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base enable, one pulse per coarse step |
| trig_in | input | NCH | Per-channel discriminator trigger |
| rd_req | input | 1 | Read request for the oldest entry of rd_ch |
| rd_ch | input | log2(NCH) | Channel to read |
| ers_req | input | 1 | Erase request for the oldest entry of ers_ch |
| ers_ch | input | log2(NCH) | Channel to erase |
| slot_full | output | NCH*DEPTH | Occupancy flag per slot, channel-major |
| hold | output | NCH*DEPTH | One-cycle hold strobe per slot |
| slot_ts | output | NCH*DEPTH*TW | Stored Gray timestamp per slot |
| ovf_flag | output | NCH | Sticky per-channel overflow |
| rd_valid | output | 1 | Read result valid pulse |
| rd_ok | output | 1 | Read channel had an entry |
| rd_ts | output | TW | Oldest timestamp of the read channel |
| any_trig | output | 1 | OR of all registered triggers |
| coarse_gray | output | TW | Current coarse time in Gray code |

## Verification
The case that matters most is an erase and a new hit reaching the same full channel on one edge. The bench sets this up by raising a trigger on a full channel and then driving the erase for that channel in the very cycle the registered edge becomes a hit. It then expects two occupied slots, the new stamp in the freed head slot, and no overflow. Random traffic mixes reads, erases and sparse triggers so that capture and removal keep landing together on other channels too. A behavioural queue model judges every cycle.

// File: rtl/hit_acq_pkg.sv
package hit_acq_pkg;
    // What a channel's slot store does on a given edge
    typedef enum logic [1:0] {
        SLOT_IDLE,
        SLOT_PUSH,
        SLOT_POP,
        SLOT_SWAP
    } slot_op_e;
endpackage

// File: rtl/hit_acq_gray_timer.sv
module hit_acq_gray_timer #(
    parameter int TW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    output logic [TW-1:0] gray
);
    typedef struct packed {
        logic [TW-1:0] bin;
        logic [TW-1:0] gray;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.bin = st_q.bin + TW'(1);   // wraps from all-ones to zero
        end
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gray = st_q.gray;
endmodule

// File: rtl/hit_acq_trig_latch.sv
module hit_acq_trig_latch #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] trig_in,
    output logic [NCH-1:0] hit,
    output logic           any_trig
);
    typedef struct packed {
        logic [NCH-1:0] lat;
        logic [NCH-1:0] prev;
    } trg_st_t;

    trg_st_t st_d, st_q;

    always_comb begin
        st_d.lat  = trig_in;
        st_d.prev = st_q.lat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Registered level held for the whole cycle; rising edge marks one hit
    assign hit      = st_q.lat & ~st_q.prev;
    assign any_trig = |st_q.lat;
endmodule

// File: rtl/hit_acq_slots.sv
module hit_acq_slots
    import hit_acq_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int TW    = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hit,
    input  logic                     erase,
    input  logic [TW-1:0]            stamp,
    output logic [DEPTH-1:0]         full,
    output logic [DEPTH-1:0]         hold,
    output logic [$clog2(DEPTH)-1:0] head,
    output logic                     ovf,
    output logic [DEPTH*TW-1:0]      ts_flat
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0]         full;
        logic [DEPTH-1:0]         hold;
        logic [PW-1:0]            head;
        logic                     ovf;
        logic [DEPTH-1:0][TW-1:0] ts;
    } slot_st_t;

    slot_st_t  st_d, st_q;
    logic [CW-1:0] used;
    logic          do_pop;
    logic          do_push;
    logic          room;
    logic [PW:0]   wsum;
    logic [PW-1:0] wr_slot;
    logic [PW-1:0] head_nxt;
    slot_op_e      op;

    always_comb begin
        used = '0;
        for (int s = 0; s < DEPTH; s++) begin
            used = used + CW'(st_q.full[s]);
        end

        do_pop  = erase && (used != '0);
        // an erase in the same cycle makes room for the incoming hit
        room    = (used - CW'(do_pop)) < CW'(DEPTH);
        do_push = hit && room;

        unique case ({do_pop, do_push})
            2'b01:   op = SLOT_PUSH;
            2'b10:   op = SLOT_POP;
            2'b11:   op = SLOT_SWAP;
            default: op = SLOT_IDLE;
        endcase

        // tail slot from the pre-edge head and count
        wsum = (PW+1)'(st_q.head) + (PW+1)'(used);
        if (wsum >= (PW+1)'(DEPTH)) begin
            wsum = wsum - (PW+1)'(DEPTH);
        end
        wr_slot  = wsum[PW-1:0];
        head_nxt = (st_q.head == PW'(DEPTH - 1)) ? '0 : st_q.head + PW'(1);

        st_d      = st_q;
        st_d.hold = '0;

        if (op == SLOT_POP || op == SLOT_SWAP) begin
            st_d.full[st_q.head] = 1'b0;
            st_d.head            = head_nxt;
        end
        if (op == SLOT_PUSH || op == SLOT_SWAP) begin
            st_d.full[wr_slot] = 1'b1;
            st_d.hold[wr_slot] = 1'b1;
            st_d.ts[wr_slot]   = stamp;
        end
        if (hit && !room) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full    = st_q.full;
    assign hold    = st_q.hold;
    assign head    = st_q.head;
    assign ovf     = st_q.ovf;
    assign ts_flat = st_q.ts;
endmodule

// File: rtl/hit_acq_mgr.sv
module hit_acq_mgr #(
    parameter int NCH   = 16,
    parameter int DEPTH = 2,
    parameter int TW    = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic [NCH-1:0]            trig_in,
    input  logic                      rd_req,
    input  logic [$clog2(NCH)-1:0]    rd_ch,
    input  logic                      ers_req,
    input  logic [$clog2(NCH)-1:0]    ers_ch,
    output logic [NCH*DEPTH-1:0]      slot_full,
    output logic [NCH*DEPTH-1:0]      hold,
    output logic [NCH*DEPTH*TW-1:0]   slot_ts,
    output logic [NCH-1:0]            ovf_flag,
    output logic                      rd_valid,
    output logic                      rd_ok,
    output logic [TW-1:0]             rd_ts,
    output logic                      any_trig,
    output logic [TW-1:0]             coarse_gray
);
    localparam int CHW = $clog2(NCH);
    localparam int PW  = $clog2(DEPTH);

    typedef struct packed {
        logic          valid;
        logic          ok;
        logic [TW-1:0] ts;
    } rd_st_t;

    logic [NCH-1:0]                     hit_w;
    logic [TW-1:0]                      gray_w;
    logic [NCH-1:0][DEPTH-1:0]          full_w;
    logic [NCH-1:0][DEPTH-1:0]          hold_w;
    logic [NCH-1:0][PW-1:0]             head_w;
    logic [NCH-1:0][DEPTH-1:0][TW-1:0]  ts_w;
    rd_st_t                             rd_d, rd_q;

    hit_acq_gray_timer #(.TW(TW)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .gray  (gray_w)
    );

    hit_acq_trig_latch #(.NCH(NCH)) i_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .hit      (hit_w),
        .any_trig (any_trig)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        hit_acq_slots #(.DEPTH(DEPTH), .TW(TW)) i_slots (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (hit_w[c]),
            .erase   (ers_req && (ers_ch == CHW'(c))),
            .stamp   (gray_w),
            .full    (full_w[c]),
            .hold    (hold_w[c]),
            .head    (head_w[c]),
            .ovf     (ovf_flag[c]),
            .ts_flat (ts_w[c])
        );
    end

    // Read port: samples the pre-edge oldest entry of the named channel
    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = rd_req;
        if (rd_req) begin
            rd_d.ok = 1'b0;
            rd_d.ts = '0;
            for (int c = 0; c < NCH; c++) begin
                if (rd_ch == CHW'(c)) begin
                    rd_d.ok = |full_w[c];
                    if (|full_w[c]) begin
                        rd_d.ts = ts_w[c][head_w[c]];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign slot_full   = full_w;
    assign hold        = hold_w;
    assign slot_ts     = ts_w;
    assign rd_valid    = rd_q.valid;
    assign rd_ok       = rd_q.ok;
    assign rd_ts       = rd_q.ts;
    assign coarse_gray = gray_w;
endmodule

// File: rtl/hit_acq_mgr_chk.sv
module hit_acq_mgr_chk #(
    parameter int NCH   = 16,
    parameter int DEPTH = 2,
    parameter int TW    = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NCH-1:0]       trig_in,
    input logic                 rd_req,
    input logic [NCH*DEPTH-1:0] slot_full,
    input logic [NCH*DEPTH-1:0] hold,
    input logic [NCH-1:0]       ovf_flag,
    input logic                 rd_valid,
    input logic                 any_trig,
    input logic [TW-1:0]        coarse_gray
);
    // R5: consecutive coarse values differ in at most one bit
    assert_gray_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(coarse_gray ^ $past(coarse_gray)) <= 1);

    // R8: OR output follows the triggers registered one edge earlier
    assert_any_trig_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (any_trig == $past(|trig_in)));

    // R9: a read result only appears after a request
    assert_rd_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R3: at most one slot of a channel is strobed per cycle
        assert_hold_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(hold[c*DEPTH +: DEPTH]));

        // R3: occupancy grows by at most one per cycle
        assert_fill_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(slot_full[c*DEPTH +: DEPTH])
                <= $countones($past(slot_full[c*DEPTH +: DEPTH])) + 1);

        // R7: overflow is sticky
        assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_flag[c] |=> ovf_flag[c]);

        // R7: overflow only rises when the channel was full
        assert_ovf_needs_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovf_flag[c]) |-> (&$past(slot_full[c*DEPTH +: DEPTH])));

        for (genvar s = 0; s < DEPTH; s++) begin : g_slot
            // R3: a strobed slot is marked occupied
            assert_hold_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
                hold[c*DEPTH+s] |-> slot_full[c*DEPTH+s]);
        end
    end
endmodule

bind hit_acq_mgr hit_acq_mgr_chk #(.NCH(NCH), .DEPTH(DEPTH), .TW(TW)) i_hit_acq_mgr_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_in     (trig_in),
    .rd_req      (rd_req),
    .slot_full   (slot_full),
    .hold        (hold),
    .ovf_flag    (ovf_flag),
    .rd_valid    (rd_valid),
    .any_trig    (any_trig),
    .coarse_gray (coarse_gray)
);

// File: tb/test_hit_acq_mgr.sv
module test_hit_acq_mgr;
    localparam int NCH   = 16;
    localparam int DEPTH = 2;
    localparam int TW    = 10;
    localparam int CHW   = 4;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    tick = 1'b0;
    logic [NCH-1:0]          trig_in = '0;
    logic                    rd_req = 1'b0;
    logic [CHW-1:0]          rd_ch = '0;
    logic                    ers_req = 1'b0;
    logic [CHW-1:0]          ers_ch = '0;
    logic [NCH*DEPTH-1:0]    slot_full;
    logic [NCH*DEPTH-1:0]    hold;
    logic [NCH*DEPTH*TW-1:0] slot_ts;
    logic [NCH-1:0]          ovf_flag;
    logic                    rd_valid, rd_ok, any_trig;
    logic [TW-1:0]           rd_ts, coarse_gray;

    hit_acq_mgr #(.NCH(NCH), .DEPTH(DEPTH), .TW(TW)) i_hit_acq_mgr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .trig_in(trig_in),
        .rd_req(rd_req), .rd_ch(rd_ch), .ers_req(ers_req), .ers_ch(ers_ch),
        .slot_full(slot_full), .hold(hold), .slot_ts(slot_ts), .ovf_flag(ovf_flag),
        .rd_valid(rd_valid), .rd_ok(rd_ok), .rd_ts(rd_ts), .any_trig(any_trig),
        .coarse_gray(coarse_gray)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc_n = 0;
    int wraps = 0;
    int g_last = 0;
    bit free_tick = 0;
    bit done = 0;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int bin_m;
    bit [NCH-1:0] lat_m, prev_m, newhit;
    bit full_m [NCH][DEPTH];
    int ts_m   [NCH][DEPTH];
    int head_m [NCH];
    bit hold_m [NCH][DEPTH];
    bit ovf_m  [NCH];
    bit rdv_m, rdok_m;
    int rdts_m;
    int n_t, h_t, w_t, g_t;
    bit pop_t;

    function automatic int gray_of(int b);
        return (b ^ (b >> 1)) & ((1 << TW) - 1);
    endfunction

    function automatic int cnt_m(int c);
        int n = 0;
        for (int s = 0; s < DEPTH; s++) n += full_m[c][s];
        return n;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            bin_m = 0; lat_m = '0; prev_m = '0;
            rdv_m = 0; rdok_m = 0; rdts_m = 0;
            for (int c = 0; c < NCH; c++) begin
                head_m[c] = 0; ovf_m[c] = 0;
                for (int s = 0; s < DEPTH; s++) begin
                    full_m[c][s] = 0; ts_m[c][s] = 0; hold_m[c][s] = 0;
                end
            end
        end else begin
            g_t = gray_of(bin_m);
            newhit = lat_m & ~prev_m;
            rdv_m = rd_req;
            if (rd_req) begin
                rdok_m = cnt_m(rd_ch) > 0;
                rdts_m = rdok_m ? ts_m[rd_ch][head_m[rd_ch]] : 0;
            end
            for (int c = 0; c < NCH; c++) begin
                for (int s = 0; s < DEPTH; s++) hold_m[c][s] = 0;
                n_t = cnt_m(c);
                h_t = head_m[c];
                pop_t = ers_req && (ers_ch == c) && (n_t > 0);
                if (pop_t) begin
                    full_m[c][h_t] = 0;
                    head_m[c] = (h_t + 1) % DEPTH;
                end
                if (newhit[c]) begin
                    if (n_t - pop_t < DEPTH) begin
                        w_t = (h_t + n_t) % DEPTH;
                        full_m[c][w_t] = 1;
                        ts_m[c][w_t] = g_t;
                        hold_m[c][w_t] = 1;
                    end else begin
                        ovf_m[c] = 1;
                    end
                end
            end
            prev_m = lat_m;
            lat_m = trig_in;
            if (tick) bin_m = (bin_m + 1) % (1 << TW);
        end
    end

    task automatic compare();
        chk("R5 coarse gray", coarse_gray, gray_of(bin_m));
        if (g_last != 0 && gray_of(bin_m) == 0) begin
            wraps++;
            chk("R6 wrap to zero", coarse_gray, 0);
        end
        g_last = gray_of(bin_m);
        chk("R8 any trigger", any_trig, |lat_m);
        chk("R9 read valid", rd_valid, rdv_m);
        if (rdv_m) begin
            chk("R9 read ok", rd_ok, rdok_m);
            if (rdok_m) chk("R9 read stamp", rd_ts, rdts_m);
        end
        for (int c = 0; c < NCH; c++) begin
            logic [DEPTH-1:0] ef, eh;
            for (int s = 0; s < DEPTH; s++) begin
                ef[s] = full_m[c][s];
                eh[s] = hold_m[c][s];
                if (full_m[c][s])
                    chk("R4 slot stamp", slot_ts[(c*DEPTH+s)*TW +: TW], ts_m[c][s]);
            end
            chk("R3 occupancy", slot_full[c*DEPTH +: DEPTH], ef);
            chk("R3 hold strobe", hold[c*DEPTH +: DEPTH], eh);
            chk("R7 overflow", ovf_flag[c], ovf_m[c]);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        compare();
        cyc_n++;
        tick = free_tick ? 1'b1 : (cyc_n % 3 == 0);
    endtask

    function automatic int occ(int c);
        return $countones(slot_full[c*DEPTH +: DEPTH]);
    endfunction

    task automatic pulse(int c);
        trig_in[c] = 1'b1; cyc();
        trig_in[c] = 1'b0; cyc();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 slots empty", slot_full, 0);
        chk("R1 overflow clear", ovf_flag, 0);
        chk("R1 coarse zero", coarse_gray, 0);
        chk("R1 no hold", hold, 0);
        chk("R1 no read", rd_valid, 0);

        // R2: long trigger gives a single hit
        trig_in[3] = 1'b1; cyc(); cyc(); cyc();
        trig_in[3] = 1'b0; cyc(); cyc(); cyc();
        chk("R2 one hit per pulse", occ(3), 1);

        // R7: third hit on a full channel is dropped
        pulse(5); pulse(5); pulse(5); cyc(); cyc();
        chk("R7 full after drop", occ(5), 2);
        chk("R7 sticky set", ovf_flag[5], 1);

        // R11: hit and erase on a full channel in the same cycle
        pulse(6); pulse(6); cyc(); cyc();
        trig_in[6] = 1'b1; cyc();
        trig_in[6] = 1'b0; ers_req = 1'b1; ers_ch = 4'd6; cyc();
        ers_req = 1'b0; cyc();
        chk("R11 still two entries", occ(6), 2);
        chk("R11 no overflow", ovf_flag[6], 0);

        // R9: reads of a filled and an empty channel
        rd_req = 1'b1; rd_ch = 4'd3; cyc();
        rd_req = 1'b0;
        chk("R9 read of filled ch", rd_ok, 1);
        chk("R9 read keeps entry", occ(3), 1);
        rd_req = 1'b1; rd_ch = 4'd0; cyc();
        rd_req = 1'b0;
        chk("R9 read of empty ch", {rd_valid, rd_ok}, 2'b10);

        // R10: erase on empty channel is ignored, head stays on slot 0
        ers_req = 1'b1; ers_ch = 4'd0; cyc();
        ers_req = 1'b0; cyc();
        pulse(0); cyc();
        chk("R10 empty erase ignored", slot_full[1:0], 2'b01);
        ers_req = 1'b1; ers_ch = 4'd3; cyc();
        ers_req = 1'b0;
        chk("R10 erase frees slot", occ(3), 0);

        // R12: all channels at once while a read and erase run
        trig_in = '1; rd_req = 1'b1; rd_ch = 4'd6; ers_req = 1'b1; ers_ch = 4'd5; cyc();
        trig_in = '0; rd_req = 1'b0; ers_req = 1'b0; cyc(); cyc();
        begin
            int ones = 0;
            for (int c = 7; c < NCH; c++) if (occ(c) == 1) ones++;
            chk("R12 all channels captured", ones, NCH - 7);
        end

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            trig_in = NCH'($urandom() & $urandom() & $urandom());
            ers_req = ($urandom() % 3) == 0;
            ers_ch  = CHW'($urandom());
            rd_req  = ($urandom() % 3) == 0;
            rd_ch   = CHW'($urandom());
            cyc();
        end
        trig_in = '0; ers_req = 1'b0; rd_req = 1'b0;

        // R6: run the counter through its wrap
        free_tick = 1;
        for (int i = 0; i < 1100; i++) cyc();
        free_tick = 0;
        cyc();
        chk("R6 wrap observed", wraps > 0, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule